// File: doc/BRIEF.md
# Parallel I/O Pin Controller

This block manages a bank of general purpose pins behind a small word-addressed register interface. Every pin carries its own configuration: whether the GPIO logic or an internal peripheral owns it, which of two peripheral functions drives it, output enable, output level, pull-up, input glitch filter, open-drain drive and interrupt enable. Each attribute changes only through a pair of mask registers, one that sets bits and one that clears them. Software can therefore reconfigure a single pin without a read-modify-write.

The pad side drives a per-pin output level, an output enable and a pull-up enable. When the GPIO logic owns a pin, its output and enable come from the GPIO state. When it does not, they come from peripheral function A or B. The pin level is always readable, whoever owns the pin. Each input can be filtered against one-cycle glitches and is then synchronized with two flops.

Top module: `pio_bank`

## Requirements
- R1: Register map (byte addresses, bits [1:0] must be 0). Attribute k has its set register at 0x10*k, its clear register at 0x10*k+4 and its read-only status at 0x10*k+8. The attributes are: k=0 GPIO ownership, 1 output enable, 2 glitch filter, 3 output data, 4 interrupt enable, 5 open-drain, 6 pull-up, 7 peripheral select (1 = B). A write to a set register makes every pin whose mask bit is 1 read back as 1 and leaves every other pin unchanged.
- R2: A write to a clear register makes every pin whose mask bit is 1 read back as 0 and leaves every other pin unchanged.
- R3: After reset, ownership and pull-up read all ones. Output enable, output data, filter, open-drain, interrupt enable and peripheral select read all zeros. pin_oe is all zeros and pin_pu is all ones.
- R4: A pin whose ownership bit is 0 takes pin_out and pin_oe from the selected peripheral, and pins still owned by the GPIO logic are not affected.
- R5: A peripheral-owned pin with select bit 0 follows peripheral A, and with select bit 1 it follows peripheral B.
- R6: On a GPIO-owned pin with open-drain off, pin_out equals the output data bit and pin_oe equals the output enable bit.
- R7: With open-drain on, pin_out is 0 and the pin is driven only while the source level is 0. A source level of 1 releases it (pin_oe = 0).
- R8: pin_pu equals the pull-up status bit of each pin.
- R9: Reading 0x80 returns the pin levels for every pin, peripheral-owned ones included. With the filter off, a pin change made between two clock edges is visible after the second edge and not after the first.
- R10: With the filter on, a level present at only one clock edge never reaches 0x80. A level that holds is visible after the fourth edge and not after the third.
- R11: Set and clear registers read as 0. Writes to status registers or to 0x80 change nothing.
- R12: The interrupt enable bits follow their set and clear masks like any other attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write mask / data |
| wen | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Combinational read data for addr |
| pin_in | input | 32 | Pad input levels |
| per_a_out | input | 32 | Peripheral A output levels |
| per_a_oe | input | 32 | Peripheral A output enables |
| per_b_out | input | 32 | Peripheral B output levels |
| per_b_oe | input | 32 | Peripheral B output enables |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables |
| pin_pu | output | 32 | Pad pull-up enables |

## Verification
The register path is exercised with masks that are sparse, dense, nibble-patterned and all-ones, written over prior state. This separates a correct OR/AND-NOT update from one that overwrites the whole word or touches neighbouring pins. Pad checks walk one pin through GPIO output, open-drain high and low, peripheral A and peripheral B, while untouched pins are watched to expose crosstalk in the mux. Input timing is probed one edge before and at the expected edge, with a one-edge pulse against the filter, which separates the filtered path, the raw path and a missing synchronizer stage.

// File: rtl/pio_pkg.sv
// Shared constants for the pin controller: attribute indices,
// the pin-level address and per-attribute reset polarity.
package pio_pkg;
    localparam int NATTR   = 8;
    localparam int A_OWN   = 0;
    localparam int A_OE    = 1;
    localparam int A_FLT   = 2;
    localparam int A_DOUT  = 3;
    localparam int A_IRQ   = 4;
    localparam int A_OD    = 5;
    localparam int A_PU    = 6;
    localparam int A_SELB  = 7;
    localparam logic [7:0] LEVEL_OFS = 8'h80;

    // Attributes that come out of reset set on every pin.
    function automatic logic on_at_reset(input int k);
        return (k == A_OWN) || (k == A_PU);
    endfunction
endpackage

// File: rtl/pio_attr_reg.sv
// One per-pin attribute vector, updated by set and clear masks.
// Assumes set_en and clr_en are never high together (distinct addresses).
module pio_attr_reg #(
    parameter int         W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    // Masked OR on set, masked AND-NOT on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST;
        else if (set_en) q <= q | mask;
        else if (clr_en) q <= q & ~mask;
    end
endmodule

// File: rtl/pio_in_cond.sv
// Input conditioning: an optional two-edge glitch filter followed by a
// two-flop synchronizer. Assumes pin inputs may be asynchronous.
module pio_in_cond #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] flt_en,
    output logic [W-1:0] level
);
    logic [W-1:0] prev_q, filt_q, sync1_q, sync2_q, pick;

    // Filter: accept a level once it was seen at two consecutive edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            filt_q <= '0;
        end else begin
            prev_q <= pin_in;
            filt_q <= (pin_in & ~(pin_in ^ prev_q)) | (filt_q & (pin_in ^ prev_q));
        end
    end

    // Per-pin choice between raw and filtered input.
    always_comb pick = (flt_en & filt_q) | (~flt_en & pin_in);

    // Two-flop synchronizer in front of the level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pick;
            sync2_q <= sync1_q;
        end
    end

    assign level = sync2_q;
endmodule

// File: rtl/pio_pad_mux.sv
// Pad drive selection: GPIO state or peripheral A/B, then open-drain
// shaping. Purely combinational.
module pio_pad_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] od,
    input  logic [W-1:0] selb,
    input  logic [W-1:0] a_out,
    input  logic [W-1:0] a_oe,
    input  logic [W-1:0] b_out,
    input  logic [W-1:0] b_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    logic [W-1:0] per_out, per_oe, src_out, src_oe;

    // Source selection per pin.
    always_comb begin
        per_out = (selb & b_out) | (~selb & a_out);
        per_oe  = (selb & b_oe)  | (~selb & a_oe);
        src_out = (own & dout) | (~own & per_out);
        src_oe  = (own & oe)   | (~own & per_oe);
    end

    // Open-drain: drive only low, release for a high.
    always_comb begin
        pin_out = src_out & ~od;
        pin_oe  = src_oe & ~(od & src_out);
    end
endmodule

// File: rtl/pio_bank.sv
// Top of the pin controller: address decode, attribute registers,
// input conditioning and pad mux. Register reads are combinational.
// Assumes an 8-bit byte address and word-aligned accesses.
module pio_bank #(
    parameter int NPIN = 32,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [NPIN-1:0] wdata,
    input  logic            wen,
    output logic [NPIN-1:0] rdata,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] per_a_out,
    input  logic [NPIN-1:0] per_a_oe,
    input  logic [NPIN-1:0] per_b_out,
    input  logic [NPIN-1:0] per_b_oe,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_pu
);
    import pio_pkg::*;

    localparam int IDX_W = $clog2(NATTR);

    logic [NATTR-1:0][NPIN-1:0] attr_q;
    logic [IDX_W-1:0] idx;
    logic [1:0]       sub;
    logic             aligned, in_attr, is_level;
    logic [NPIN-1:0]  level;

    // Address field split.
    always_comb begin
        idx      = addr[4 +: IDX_W];
        sub      = addr[3:2];
        aligned  = (addr[1:0] == 2'b00);
        in_attr  = aligned && (addr[AW-1:4+IDX_W] == '0);
        is_level = (addr == AW'(LEVEL_OFS));
    end

    // One set/clear register per attribute.
    for (genvar k = 0; k < NATTR; k++) begin : g_attr
        logic hit;
        assign hit = in_attr && (idx == IDX_W'(k));
        pio_attr_reg #(
            .W   (NPIN),
            .RST (on_at_reset(k) ? {NPIN{1'b1}} : {NPIN{1'b0}})
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (wen && hit && (sub == 2'd0)),
            .clr_en (wen && hit && (sub == 2'd1)),
            .mask   (wdata),
            .q      (attr_q[k])
        );
    end

    pio_in_cond #(.W(NPIN)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .flt_en (attr_q[A_FLT]),
        .level  (level)
    );

    pio_pad_mux #(.W(NPIN)) u_mux (
        .own     (attr_q[A_OWN]),
        .oe      (attr_q[A_OE]),
        .dout    (attr_q[A_DOUT]),
        .od      (attr_q[A_OD]),
        .selb    (attr_q[A_SELB]),
        .a_out   (per_a_out),
        .a_oe    (per_a_oe),
        .b_out   (per_b_out),
        .b_oe    (per_b_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign pin_pu = attr_q[A_PU];

    // Read mux: status words and pin levels; everything else reads 0.
    always_comb begin
        rdata = '0;
        if (is_level)                     rdata = level;
        else if (in_attr && sub == 2'd2)  rdata = attr_q[idx];
    end
endmodule

// File: rtl/pio_bank_chk.sv
// Assertion checker for pio_bank, bound to every instance.
module pio_bank_chk #(
    parameter int NPIN = 32,
    parameter int AW   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [AW-1:0]              addr,
    input logic [NPIN-1:0]            wdata,
    input logic                       wen,
    input logic [NPIN-1:0]            pin_out,
    input logic [NPIN-1:0]            pin_oe,
    input logic [pio_pkg::NATTR-1:0][NPIN-1:0] attr_q
);
    import pio_pkg::*;

    // R1
    set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == AW'(8'h10)) |=> ((attr_q[A_OE] & $past(wdata)) == $past(wdata)));

    // R2
    clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == AW'(8'h34)) |=> ((attr_q[A_DOUT] & $past(wdata)) == '0));

    // R11
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == AW'(8'h08)) |=> $stable(attr_q[A_OWN]));

    // R7
    od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((attr_q[A_OD] & pin_out) == '0));

    // R6
    gpio_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe ^ attr_q[A_OE]) | (pin_out ^ attr_q[A_DOUT]))
         & attr_q[A_OWN] & ~attr_q[A_OD]) == '0);
endmodule

bind pio_bank pio_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wen     (wen),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .attr_q  (attr_q)
);

// File: tb/sim_pio_bank.sv
module sim_pio_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wen = 1'b0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;
    logic [31:0] pin_out, pin_oe, pin_pu;

    int n_chk = 0;
    int n_fail = 0;

    pio_bank u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wen(wen),
        .rdata(rdata), .pin_in(pin_in),
        .per_a_out(per_a_out), .per_a_oe(per_a_oe),
        .per_b_out(per_b_out), .per_b_oe(per_b_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {write addr, write mask, read addr, expected read}
    localparam logic [79:0] VEC [NV] = '{
        {8'h10, 32'h0000_00FF, 8'h18, 32'h0000_00FF},
        {8'h14, 32'h0000_000F, 8'h18, 32'h0000_00F0},
        {8'h30, 32'hA5A5_0000, 8'h38, 32'hA5A5_0000},
        {8'h34, 32'h8000_0000, 8'h38, 32'h25A5_0000},
        {8'h04, 32'h0000_0003, 8'h08, 32'hFFFF_FFFC},
        {8'h70, 32'h0000_0002, 8'h78, 32'h0000_0002},
        {8'h64, 32'hFFFF_0000, 8'h68, 32'h0000_FFFF},
        {8'h50, 32'h0000_0100, 8'h58, 32'h0000_0100},
        {8'h40, 32'h0000_F00F, 8'h48, 32'h0000_F00F},
        {8'h44, 32'h0000_000F, 8'h48, 32'h0000_F000},
        {8'h20, 32'h0000_0001, 8'h28, 32'h0000_0001},
        {8'h08, 32'h0000_0000, 8'h08, 32'hFFFF_FFFC},
        {8'h30, 32'hFFFF_FFFF, 8'h30, 32'h0000_0000},
        {8'h74, 32'h0000_0002, 8'h78, 32'h0000_0000}
    };

    function automatic string vec_tag(input int i);
        case (i)
            1, 3, 4, 6, 13: return "R2";
            8, 9:           return "R12";
            11, 12:         return "R11";
            default:        return "R1";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R3 reset state
        rd_check("R3", 8'h08, 32'hFFFF_FFFF);
        rd_check("R3", 8'h68, 32'hFFFF_FFFF);
        rd_check("R3", 8'h18, 32'h0);
        rd_check("R3", 8'h38, 32'h0);
        rd_check("R3", 8'h48, 32'h0);
        rd_check("R3", 8'h78, 32'h0);
        check("R3", pin_oe, 32'h0);
        check("R3", pin_pu, 32'hFFFF_FFFF);

        // Table walk: R1 R2 R11 R12 register behaviour
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][79:72], VEC[i][71:40]);
            rd_check(vec_tag(i), VEC[i][39:32], VEC[i][31:0]);
        end

        // Directed pad tests from a fresh reset
        do_reset();
        per_a_out = 32'h0000_0010; per_a_oe = 32'h0000_0010;
        per_b_out = 32'h0000_0000; per_b_oe = 32'h0000_0010;

        // R6 GPIO output, level written before enable
        wr(8'h30, 32'h1);
        check("R6", pin_oe & 32'h1, 32'h0);
        wr(8'h10, 32'h1);
        check("R6", pin_oe & 32'h3, 32'h1);
        check("R6", pin_out & 32'h1, 32'h1);

        // R7 open-drain release for high, drive for low
        wr(8'h50, 32'h1);
        check("R7", pin_oe & 32'h1, 32'h0);
        wr(8'h34, 32'h1);
        check("R7", pin_oe & 32'h1, 32'h1);
        check("R7", pin_out & 32'h1, 32'h0);

        // R4 hand pin 4 to the peripheral (A by default)
        wr(8'h04, 32'h10);
        check("R4", pin_out & 32'h30, 32'h10);
        check("R4", pin_oe & 32'h30, 32'h10);
        // R5 select peripheral B
        wr(8'h70, 32'h10);
        check("R5", pin_out & 32'h10, 32'h0);
        check("R5", pin_oe & 32'h10, 32'h10);

        // R8 pull-up clear on pin 2 only
        wr(8'h64, 32'h4);
        check("R8", pin_pu & 32'hC, 32'h8);

        // R9 level of peripheral-owned pin 4, unfiltered latency
        addr = 8'h80;
        @(negedge clk);
        pin_in[4] = 1'b1;
        @(negedge clk); #1;
        check("R9", rdata & 32'h10, 32'h0);
        @(negedge clk); #1;
        check("R9", rdata & 32'h10, 32'h10);

        // R10 filter on pin 8: one-edge glitch rejected
        wr(8'h20, 32'h100);
        addr = 8'h80;
        pin_in[8] = 1'b1;
        @(negedge clk);
        pin_in[8] = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        check("R10", rdata & 32'h100, 32'h0);
        // R10 steady level: visible after 4th edge, not after 3rd
        pin_in[8] = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R10", rdata & 32'h100, 32'h0);
        @(negedge clk); #1;
        check("R10", rdata & 32'h100, 32'h100);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule